// File: doc/BRIEF.md
# Power-up nonvolatile register loader

After reset, this block fetches start-up values for a working register file from a 256-word by 16-bit nonvolatile store. The store has a synchronous read port with one cycle of latency. The block first reads a signature word. If the signature is wrong, the store is treated as blank, nothing is copied, and the working registers keep their reset defaults.

If the signature is right, the block walks two address windows in ascending order and copies each word to the same address in the register file. Every word in the first window is copied. A word in the second window is copied only when its top bit is set, and in that case the full 16-bit word, flag included, is written.

Each word takes two cycles: one read request cycle, then one cycle in which the word is written or dropped. When the pass ends, or is bypassed, `load_done` goes high and stays high until the next reset. The host side keeps its register accesses back until that point. There is no path from the register file back into the store.

The states are:
- `ST_SIG_REQ`: reset state, requests the signature address.
- `ST_SIG_WAIT`: compares the returned word. On a match it goes to `ST_COPY_REQ`; otherwise it goes to `ST_DONE`.
- `ST_COPY_REQ`: requests the cursor address and always goes to `ST_COPY_WAIT`.
- `ST_COPY_WAIT`: writes or drops the word. After the last word it goes to `ST_DONE`; otherwise it advances the cursor and returns to `ST_COPY_REQ`.
- `ST_DONE`: holds until reset.

Top module: `nvload_top`

## Requirements
- R1: In the first cycle after reset is released, the block drives `mem_rd_en`=1 with `mem_addr`=0x37, and no other address is read before it.
- R2: If the word at 0x37 is not exactly 0xAA55, there is no write strobe. `load_done` goes high in the third cycle after reset release, and every working register keeps its reset value.
- R3: With a valid signature, every address from 0x10 to 0x1F is written with its full 16-bit word, at the same register address.
- R4: For addresses 0x2C to 0x33, a write happens only if bit 15 of the word is 1, and the written word still carries that bit. A word with bit 15 = 0 produces no write strobe, and that register keeps its reset value.
- R5: Words are handled in ascending address order, 0x10 to 0x1F and then 0x2C to 0x33. Each read request is one cycle long and is followed by one cycle without a request. Any write strobe falls in that following cycle and uses the address just requested.
- R6: With a valid signature, `load_done` goes high in cycle 50 after release (cycle 0 being the first). Once high, it stays high with no further reads or writes until reset.
- R7: No address outside 0x37, 0x10–0x1F and 0x2C–0x33 is ever read, and no address outside 0x10–0x1F and 0x2C–0x33 is ever written.
- R8: Asserting reset in the middle of a pass restarts the sequence from the signature read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Read request to the nonvolatile store |
| mem_addr | output | 8 | Read address to the store |
| mem_rdata | input | 16 | Store data, valid one cycle after the request |
| reg_we | output | 1 | Working register write strobe |
| reg_addr | output | 8 | Working register address |
| reg_wdata | output | 16 | Working register write data |
| load_done | output | 1 | Load finished or bypassed; sticky until reset |

## Verification
The sequencer is driven with five store images:
- **Valid signature, alternating flags.** The flags in the conditional window alternate, and some words in the always-copied window have bit 15 cleared. This separates the per-word gate from the window decode.
- **Two near-miss signatures (0xAA54 and the byte-swapped 0x55AA).** These show that the compare uses the whole word.
- **All flags clear and all flags set.** These cover both extremes of the gate.

A reset partway through a pass shows that the sequence restarts at the signature. A behavioural model predicts every cycle, so an off-by-one in latency, ordering or done timing is caught where it happens. Register-file contents are also compared against the reset defaults.

// File: rtl/nvload_pkg.sv
package nvload_pkg;

    typedef enum logic [2:0] {
        ST_SIG_REQ   = 3'd0,
        ST_SIG_WAIT  = 3'd1,
        ST_COPY_REQ  = 3'd2,
        ST_COPY_WAIT = 3'd3,
        ST_DONE      = 3'd4
    } nvl_state_e;

endpackage

// File: rtl/nvload_step.sv
// Cursor advance: walks the always-copied window, then jumps to the
// conditional window; flags the final address of the pass.
module nvload_step #(
    parameter int AW     = 8,
    parameter int ALW_HI = 'h1F,
    parameter int CND_LO = 'h2C,
    parameter int CND_HI = 'h33
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt,
    output logic          last
);
    localparam logic [AW-1:0] A_HI = AW'(ALW_HI);
    localparam logic [AW-1:0] C_LO = AW'(CND_LO);
    localparam logic [AW-1:0] C_HI = AW'(CND_HI);

    always_comb begin
        if (cur == A_HI) nxt = C_LO;
        else             nxt = cur + 1'b1;
        last = (cur == C_HI);
    end
endmodule

// File: rtl/nvload_gate.sv
// Decides whether the word just returned is to be written.
module nvload_gate #(
    parameter int AW     = 8,
    parameter int CND_LO = 'h2C,
    parameter int CND_HI = 'h33
) (
    input  logic [AW-1:0] addr,
    input  logic          flag,
    output logic          copy_ok
);
    localparam logic [AW-1:0] C_LO = AW'(CND_LO);
    localparam logic [AW-1:0] C_HI = AW'(CND_HI);

    logic in_cond;
    always_comb begin
        in_cond = (addr >= C_LO) && (addr <= C_HI);
        copy_ok = in_cond ? flag : 1'b1;
    end
endmodule

// File: rtl/nvload_fsm.sv
module nvload_fsm
    import nvload_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int SIG_ADDR   = 'h37,
    parameter int SIG_VALUE  = 'hAA55,
    parameter int START_ADDR = 'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] step_nxt,
    input  logic          step_last,
    input  logic          copy_ok,
    output logic [AW-1:0] cursor,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          load_done
);
    localparam logic [AW-1:0] SIG_A = AW'(SIG_ADDR);
    localparam logic [DW-1:0] SIG_W = DW'(SIG_VALUE);
    localparam logic [AW-1:0] ST_A  = AW'(START_ADDR);

    nvl_state_e    state_q, state_d;
    logic [AW-1:0] cursor_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SIG_REQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cursor_q <= ST_A;
        else if (state_q == ST_COPY_WAIT && !step_last)
            cursor_q <= step_nxt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SIG_REQ:   state_d = ST_SIG_WAIT;
            ST_SIG_WAIT:  state_d = (mem_rdata == SIG_W) ? ST_COPY_REQ : ST_DONE;
            ST_COPY_REQ:  state_d = ST_COPY_WAIT;
            ST_COPY_WAIT: state_d = step_last ? ST_DONE : ST_COPY_REQ;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_SIG_REQ;
        endcase
    end

    always_comb begin
        mem_rd_en = (state_q == ST_SIG_REQ) || (state_q == ST_COPY_REQ);
        mem_addr  = (state_q == ST_SIG_REQ) ? SIG_A : cursor_q;
        reg_we    = (state_q == ST_COPY_WAIT) && copy_ok;
        reg_addr  = cursor_q;
        reg_wdata = mem_rdata;
        load_done = (state_q == ST_DONE);
    end

    assign cursor = cursor_q;
endmodule

// File: rtl/nvload_top.sv
module nvload_top #(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int SIG_ADDR  = 'h37,
    parameter int SIG_VALUE = 'hAA55,
    parameter int ALW_LO    = 'h10,
    parameter int ALW_HI    = 'h1F,
    parameter int CND_LO    = 'h2C,
    parameter int CND_HI    = 'h33,
    parameter int FLAG_BIT  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          load_done
);
    logic [AW-1:0] cursor, step_nxt;
    logic          step_last, copy_ok;

    nvload_step #(.AW(AW), .ALW_HI(ALW_HI), .CND_LO(CND_LO), .CND_HI(CND_HI)) u_step (
        .cur  (cursor),
        .nxt  (step_nxt),
        .last (step_last)
    );

    nvload_gate #(.AW(AW), .CND_LO(CND_LO), .CND_HI(CND_HI)) u_gate (
        .addr    (cursor),
        .flag    (mem_rdata[FLAG_BIT]),
        .copy_ok (copy_ok)
    );

    nvload_fsm #(
        .AW(AW), .DW(DW), .SIG_ADDR(SIG_ADDR), .SIG_VALUE(SIG_VALUE), .START_ADDR(ALW_LO)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .step_nxt  (step_nxt),
        .step_last (step_last),
        .copy_ok   (copy_ok),
        .cursor    (cursor),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .load_done (load_done)
    );
endmodule

// File: rtl/nvload_chk.sv
module nvload_chk #(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int SIG_ADDR  = 'h37,
    parameter int ALW_LO    = 'h10,
    parameter int ALW_HI    = 'h1F,
    parameter int CND_LO    = 'h2C,
    parameter int CND_HI    = 'h33,
    parameter int FLAG_BIT  = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          load_done
);
    localparam logic [AW-1:0] SA = AW'(SIG_ADDR);
    localparam logic [AW-1:0] AL = AW'(ALW_LO);
    localparam logic [AW-1:0] AH = AW'(ALW_HI);
    localparam logic [AW-1:0] CL = AW'(CND_LO);
    localparam logic [AW-1:0] CH = AW'(CND_HI);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);                                         // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!mem_rd_en && !reg_we));                           // R6
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(mem_rd_en) && $past(mem_addr) == reg_addr));    // R5
    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);                                        // R5
    AST_COND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr >= CL && reg_addr <= CH) |-> reg_wdata[FLAG_BIT]); // R4
    AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr == SA || (mem_addr >= AL && mem_addr <= AH)
                       || (mem_addr >= CL && mem_addr <= CH)));           // R7
    AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ((reg_addr >= AL && reg_addr <= AH)
                    || (reg_addr >= CL && reg_addr <= CH)));              // R7
endmodule

bind nvload_top nvload_chk #(
    .AW(AW), .DW(DW), .SIG_ADDR(SIG_ADDR), .ALW_LO(ALW_LO), .ALW_HI(ALW_HI),
    .CND_LO(CND_LO), .CND_HI(CND_HI), .FLAG_BIT(FLAG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .load_done (load_done)
);

// File: tb/sim_nvload_top.sv
module sim_nvload_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        mem_rd_en, reg_we, load_done;
    logic [7:0]  mem_addr, reg_addr;
    logic [15:0] mem_rdata = 16'h0, reg_wdata;

    logic [15:0] mem [256];
    logic [15:0] rf  [256];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit        rd;
        bit [7:0]  a;
        bit        we;
        bit [7:0]  wa;
        bit [15:0] wd;
        bit        dn;
    } cyc_t;
    cyc_t exp_q[$];

    nvload_top u0 (
        .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .load_done(load_done)
    );

    // store model: one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];
    // working register file model
    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    function automatic bit in_alw(int a); return a >= 'h10 && a <= 'h1F; endfunction
    function automatic bit in_cnd(int a); return a >= 'h2C && a <= 'h33; endfunction
    function automatic bit sig_ok(); return mem['h37] == 16'hAA55; endfunction

    // flagmode: 0 alternate, 1 all clear, 2 all set
    task automatic fill(input logic [15:0] sig, input int flagmode);
        for (int a = 0; a < 256; a++) begin
            logic [15:0] w = 16'((a * 'h0123) ^ 'h5A00);
            if (in_cnd(a)) begin
                if (flagmode == 0)      w[15] = a[0];
                else if (flagmode == 1) w[15] = 1'b0;
                else                    w[15] = 1'b1;
            end
            mem[a] = w;
        end
        mem['h37] = sig;
    endtask

    task automatic build();
        cyc_t c;
        exp_q.delete();
        c = '{1, 8'h37, 0, 0, 0, 0}; exp_q.push_back(c);
        c = '{0, 0, 0, 0, 0, 0};     exp_q.push_back(c);
        if (sig_ok()) begin
            for (int a = 0; a < 256; a++) begin
                if (in_alw(a) || in_cnd(a)) begin
                    c = '{1, 8'(a), 0, 0, 0, 0}; exp_q.push_back(c);
                    c = '{0, 0, (in_alw(a) || mem[a][15]), 8'(a), mem[a], 0};
                    exp_q.push_back(c);
                end
            end
        end
        for (int k = 0; k < 6; k++) begin
            c = '{0, 0, 0, 0, 0, 1}; exp_q.push_back(c);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) rf[a] = 16'hC000 | 16'(a);
        rst_n = 1'b1;
    endtask

    // compares up to 'limit' cycles from the release point
    task automatic run_trace(input string first_tag, input int limit);
        int n = (limit < exp_q.size()) ? limit : exp_q.size();
        for (int i = 0; i < n; i++) begin
            cyc_t e = exp_q[i];
            bit bad;
            string tag;
            if (i > 0) @(negedge clk);
            #1;
            bad = (mem_rd_en !== e.rd) || (reg_we !== e.we) || (load_done !== e.dn)
                  || (e.rd && mem_addr !== e.a)
                  || (e.we && (reg_addr !== e.wa || reg_wdata !== e.wd));
            tag = (i == 0) ? first_tag : (e.dn || load_done) ? "R6" :
                  (e.we || reg_we) ? "R3/R4" : "R5";
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s cycle %0d actual rd=%0b a=%h we=%0b wa=%h wd=%h dn=%0b expected rd=%0b a=%h we=%0b wa=%h wd=%h dn=%0b",
                         tag, i, mem_rd_en, mem_addr, reg_we, reg_addr, reg_wdata, load_done,
                         e.rd, e.a, e.we, e.wa, e.wd, e.dn);
            end
        end
    endtask

    task automatic check_rf();
        for (int a = 0; a < 256; a++) begin
            logic [15:0] want;
            string tag;
            bit copy = sig_ok() && (in_alw(a) || (in_cnd(a) && mem[a][15]));
            want = copy ? mem[a] : (16'hC000 | 16'(a));
            tag = !sig_ok() ? "R2" : in_alw(a) ? "R3" : in_cnd(a) ? "R4" : "R7";
            checks++;
            if (rf[a] !== want) begin
                errors++;
                $display("FAIL %s reg %h actual %h expected %h", tag, a, rf[a], want);
            end
        end
    endtask

    task automatic scenario(input logic [15:0] sig, input int flagmode);
        fill(sig, flagmode);
        build();
        do_reset();
        run_trace("R1", exp_q.size());
        check_rf();
    endtask

    initial begin
        // reset state: outputs while held in reset
        fill(16'hAA55, 0);
        #9;
        checks++;
        if (reg_we !== 1'b0 || load_done !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual we=%0b done=%0b expected we=0 done=0",
                     reg_we, load_done);
        end
        scenario(16'hAA55, 0);   // R3 R4 R5 R6: mixed flags
        scenario(16'hAA54, 0);   // R2: one bit off
        scenario(16'h55AA, 2);   // R2: byte-swapped signature
        scenario(16'hAA55, 1);   // R4: every flag clear
        // R8: reset partway through a pass, then a full pass again
        fill(16'hAA55, 2);
        build();
        do_reset();
        run_trace("R1", 13);
        do_reset();
        run_trace("R8", exp_q.size());
        check_rf();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule